// File: doc/BRIEF.md
# Flash Access Violation Detector

This block watches every flash-related access a processor core issues and decides, cycle by cycle, whether that access is illegal. It sees three kinds of access. The first is a data-space write that counts as a flash write or erase because the write-enable mode bit is set. The second is a code-constant read. The third is an instruction fetch. All three are compared against one programmable lock address. Two further conditions apply only to some kinds of access. A security-restriction input blocks any flash access. A disabled supply monitor forbids flash writes and erases.

When an access is illegal, the block raises a registered single-cycle violation pulse for the system reset controller, together with a 3-bit cause code. The cause codes are: 1 for a write above the lock address, 2 for a constant read above it, 3 for a fetch above it, 4 for a security block, and 5 for a write while the supply monitor is off. If several conditions hold in one cycle, the lowest code is reported. The block holds no other state.

Top module: `flash_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `violPulse` is 0 and `violCause` is 0.
- R2: A flash write (`wrStrobe`=1 with `wrEnMode`=1) whose address is above `lockAddr` raises `violPulse` with `violCause`=1 on the next clock edge.
- R3: A constant read (`constRdStrobe`=1) whose address is above `lockAddr` reports `violCause`=2 on the next edge, unless a lower code applies.
- R4: An instruction fetch (`fetchStrobe`=1) whose address is above `lockAddr` reports `violCause`=3 on the next edge, unless a lower code applies.
- R5: Addresses compare as 16-bit unsigned values with strictly-greater-than. An access exactly at `lockAddr`, or below it, never triggers codes 1 to 3.
- R6: `secBlock`=1 together with any flash access (flash write, constant read or fetch) reports `violCause`=4, unless a lower code applies.
- R7: A flash write while `supplyOn`=0 reports `violCause`=5, unless a lower code applies.
- R8: A data write with `wrEnMode`=0 is not a flash access. It never produces a violation, whatever the address, `secBlock` or `supplyOn`.
- R9: When several conditions hold in one cycle, the numerically lowest cause code is reported.
- R10: Each output cycle reflects only the accesses of the previous input cycle. `violPulse` is 1 exactly when `violCause` is nonzero, and a cycle with no offending access drives both to 0.
- R11: `secBlock`=1 or `supplyOn`=0 with no access strobe active produces no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStrobe | input | 1 | Data-space write strobe |
| wrEnMode | input | 1 | Flash write-enable mode bit; with wrStrobe marks a flash write or erase |
| constRdStrobe | input | 1 | Code-constant read strobe |
| fetchStrobe | input | 1 | Instruction fetch strobe |
| accAddr | input | 16 | Target address of the current access |
| lockAddr | input | 16 | Highest legal address (inclusive) |
| secBlock | input | 1 | Security restriction blocks the current access |
| supplyOn | input | 1 | Supply monitor enabled |
| violPulse | output | 1 | Registered one-cycle violation pulse |
| violCause | output | 3 | Cause code of the violation, 0 when none |

## Verification
The hardest situations to reach are priority collisions near the boundary. In these, several conditions hold at once, or the address sits exactly on the lock address or straddles the sign bit, so that a wrong comparison or a wrong priority order changes the code. The bench sweeps all 64 combinations of the six control inputs against addresses just below, equal to and just above several lock values. The lock values include 0x7FFF and 0xFFFE, so signed comparisons and off-by-one bounds show up. Each combination is applied for one cycle and immediately followed by the next, so a pulse that lingers is caught as well.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_WRITE  = 3'd1,
    CAUSE_CONST  = 3'd2,
    CAUSE_FETCH  = 3'd3,
    CAUSE_SECURE = 3'd4,
    CAUSE_SUPPLY = 3'd5
  } cause_e;

  // Condition strobes from the datapath to the control
  typedef struct packed {
    logic wrHigh;
    logic constHigh;
    logic fetchHigh;
    logic secHit;
    logic supplyHit;
  } hit_t;
endpackage

// File: rtl/flash_guard_dp.sv
module flash_guard_dp
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wrStrobe,
  input  logic              wrEnMode,
  input  logic              constRdStrobe,
  input  logic              fetchStrobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [ADDR_W-1:0] lockAddr,
  input  logic              secBlock,
  input  logic              supplyOn,
  output hit_t              hits
);
  logic aboveLock;
  logic flashWrite;
  logic anyFlash;

  // unsigned, strictly greater: the lock address itself is legal
  assign aboveLock  = accAddr > lockAddr;
  assign flashWrite = wrStrobe & wrEnMode;
  assign anyFlash   = flashWrite | constRdStrobe | fetchStrobe;

  always_comb begin
    hits.wrHigh    = flashWrite & aboveLock;
    hits.constHigh = constRdStrobe & aboveLock;
    hits.fetchHigh = fetchStrobe & aboveLock;
    hits.secHit    = anyFlash & secBlock;
    hits.supplyHit = flashWrite & ~supplyOn;
  end
endmodule

// File: rtl/flash_guard_ctl.sv
module flash_guard_ctl
  import flash_guard_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  hit_t               hits,
  output logic               violPulse,
  output logic [CAUSE_W-1:0] violCause
);
  cause_e nextCause;

  // lowest code wins
  always_comb begin
    if (hits.wrHigh)         nextCause = CAUSE_WRITE;
    else if (hits.constHigh) nextCause = CAUSE_CONST;
    else if (hits.fetchHigh) nextCause = CAUSE_FETCH;
    else if (hits.secHit)    nextCause = CAUSE_SECURE;
    else if (hits.supplyHit) nextCause = CAUSE_SUPPLY;
    else                     nextCause = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violPulse <= 1'b0;
      violCause <= '0;
    end else begin
      violPulse <= (nextCause != CAUSE_NONE);
      violCause <= nextCause;
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic              wrEnMode,
  input  logic              constRdStrobe,
  input  logic              fetchStrobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [ADDR_W-1:0] lockAddr,
  input  logic              secBlock,
  input  logic              supplyOn,
  output logic              violPulse,
  output logic [2:0]        violCause
);
  hit_t hits;

  flash_guard_dp #(.ADDR_W(ADDR_W)) u_dp (
    .wrStrobe(wrStrobe), .wrEnMode(wrEnMode), .constRdStrobe(constRdStrobe),
    .fetchStrobe(fetchStrobe), .accAddr(accAddr), .lockAddr(lockAddr),
    .secBlock(secBlock), .supplyOn(supplyOn), .hits(hits)
  );

  flash_guard_ctl u_ctl (
    .clk(clk), .rstN(rstN), .hits(hits),
    .violPulse(violPulse), .violCause(violCause)
  );
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStrobe,
  input logic              wrEnMode,
  input logic              constRdStrobe,
  input logic              fetchStrobe,
  input logic [ADDR_W-1:0] accAddr,
  input logic [ADDR_W-1:0] lockAddr,
  input logic              secBlock,
  input logic              supplyOn,
  input logic              violPulse,
  input logic [2:0]        violCause
);
  logic fw;
  assign fw = wrStrobe & wrEnMode;

  assert_write_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fw && accAddr > lockAddr) |=> (violPulse && violCause == 3'd1));

  assert_const_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (constRdStrobe && accAddr > lockAddr && !fw) |=> (violCause == 3'd2));

  assert_fetch_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fetchStrobe && accAddr > lockAddr && !fw && !constRdStrobe) |=> (violCause == 3'd3));

  assert_at_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accAddr <= lockAddr && !secBlock && (supplyOn || !fw)) |=> !violPulse);

  assert_secure_R6: assert property (@(posedge clk) disable iff (!rstN)
    (secBlock && (fw || constRdStrobe || fetchStrobe) && accAddr <= lockAddr) |=> (violCause == 3'd4));

  assert_supply_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fw && !supplyOn && !secBlock && accAddr <= lockAddr) |=> (violCause == 3'd5));

  assert_mode_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEnMode && !constRdStrobe && !fetchStrobe) |=> !violPulse);

  assert_pulse_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    violPulse |-> (violCause != 3'd0 && violCause <= 3'd5));

  assert_idle_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    !violPulse |-> (violCause == 3'd0));
endmodule

bind flash_guard flash_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrEnMode(wrEnMode),
  .constRdStrobe(constRdStrobe), .fetchStrobe(fetchStrobe), .accAddr(accAddr),
  .lockAddr(lockAddr), .secBlock(secBlock), .supplyOn(supplyOn),
  .violPulse(violPulse), .violCause(violCause)
);

// File: tb/flash_guard_bench.sv
module flash_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrStrobe, wrEnMode, constRdStrobe, fetchStrobe, secBlock, supplyOn;
  logic [15:0] accAddr, lockAddr;
  logic        violPulse;
  logic [2:0]  violCause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard u_flash_guard (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrEnMode(wrEnMode),
    .constRdStrobe(constRdStrobe), .fetchStrobe(fetchStrobe), .accAddr(accAddr),
    .lockAddr(lockAddr), .secBlock(secBlock), .supplyOn(supplyOn),
    .violPulse(violPulse), .violCause(violCause)
  );

  task automatic check(input string req, input int expCause);
    checks++;
    if (violCause !== 3'(expCause) || violPulse !== (expCause != 0)) begin
      errors++;
      $display("FAIL %s addr=%h lock=%h got pulse=%0b cause=%0d expected pulse=%0b cause=%0d",
               req, accAddr, lockAddr, violPulse, violCause, expCause != 0, expCause);
    end
  endtask

  task automatic idleInputs();
    wrStrobe = 0; wrEnMode = 0; constRdStrobe = 0; fetchStrobe = 0;
    secBlock = 0; supplyOn = 1; accAddr = '0; lockAddr = '0;
  endtask

  initial begin
    int lockList [4] = '{16'h0001, 16'h7FFF, 16'h8000, 16'hFFFE};
    idleInputs();
    rstN = 0;
    repeat (3) @(negedge clk);
    check("R1", 0);
    rstN = 1;
    @(negedge clk);
    check("R1", 0);

    // R11: restriction inputs alone
    secBlock = 1; supplyOn = 0; accAddr = 16'hFFFF; lockAddr = 16'h0000;
    @(negedge clk);
    check("R11", 0);

    foreach (lockList[li]) begin
      for (int cls = 0; cls < 3; cls++) begin
        for (int bits = 0; bits < 64; bits++) begin
          int lk, ad, exp, nCond;
          bit w, m, r, f, s, p, fw, any, above;
          string tag;
          lk = lockList[li];
          ad = (cls == 0) ? lk - 1 : (cls == 1) ? lk : lk + 1;
          {w, m, r, f, s, p} = 6'(bits);
          wrStrobe = w; wrEnMode = m; constRdStrobe = r; fetchStrobe = f;
          secBlock = s; supplyOn = p;
          accAddr = 16'(ad); lockAddr = 16'(lk);
          fw = w & m; any = fw | r | f; above = ad > lk;
          nCond = int'(fw & above) + int'(r & above) + int'(f & above)
                + int'(s & any) + int'(fw & !p);
          if (fw && above)     begin exp = 1; tag = "R2"; end
          else if (r && above) begin exp = 2; tag = "R3"; end
          else if (f && above) begin exp = 3; tag = "R4"; end
          else if (s && any)   begin exp = 4; tag = "R6"; end
          else if (fw && !p)   begin exp = 5; tag = "R7"; end
          else begin
            exp = 0;
            if (w && !m && !r && !f) tag = "R8";
            else if (any && cls == 1) tag = "R5";
            else tag = "R10";
          end
          if (nCond > 1) tag = "R9";
          @(negedge clk);
          check(tag, exp);
        end
      end
    end

    // R10: pulse drops once the offending access goes away
    idleInputs();
    wrStrobe = 1; wrEnMode = 1; accAddr = 16'h9000; lockAddr = 16'h8FFF;
    @(negedge clk);
    check("R2", 1);
    idleInputs();
    @(negedge clk);
    check("R10", 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule